// File: doc/BRIEF.md
# Outbound Configuration Address Translator

This block sits in the outbound path of a root port and turns a local configuration access into either a local register access or a translated configuration request. A request names a bus, a device, a function and a register offset. The block aligns the offset to a 32-bit word and checks that the target can exist on the first two buses. It then takes one of two paths. An access to the root's own bus (bus 0) goes straight to the local register path and does not use the translation window. Every other legal access is placed in the top 1 MB of a 16 MB space and checked against a programmable window. A hit yields a translated target address and a configuration transaction type.

A small programmable register set holds the window's lower and upper bounds, an upper target word, and a control word whose bit 31 enables the window. Every outcome appears as a registered single-cycle pulse one clock after the request. There are four outcomes: local access, translation, miss, and all-ones read data for a target that cannot exist.

Top module: `cfg_xlate_win`

## Requirements
- R1: While reset is held and after it is released with no request, the outputs `loc_vld`, `xl_vld`, `miss_vld` and `inv_rd_vld` are all low. The window enable resets to off, and base, limit and upper target reset to zero.
- R2: A request to bus 0 with device 0 or 1 raises `loc_vld` one cycle later. `loc_off` carries the request offset with its two low bits cleared, and `loc_wr` and `loc_wdata` carry the request's direction and data. The window registers play no part in this path.
- R3: Device numbers of 2 and above on bus 0, and of 1 and above on bus 1, are illegal. An illegal read raises `inv_rd_vld` one cycle later with `inv_rdata` = 0xFFFFFFFF. An illegal write raises no output pulse at all.
- R4: A translated request to bus 1 carries `xl_type` = 4 (config type 0). A translated request to bus 2 or above carries `xl_type` = 5 (config type 1). Memory would be code 0 and I/O code 2.
- R5: On a hit, `xl_addr` holds the bus in bits 31:24, the device in 23:19, the function in 18:16, zero in 15:12 and the word-aligned offset in 11:0. `xl_addr_hi` holds the upper target register. `xl_wr` and `xl_wdata` follow the request.
- R6: The compared address is 0x01F00000 plus the aligned offset. This places the window in the top 1 MB of the 16 MB space based at 0x01000000. The request hits only if this address lies between base and limit, both bounds inclusive. Otherwise `miss_vld` pulses one cycle later.
- R7: While bit 31 of the control register is clear, every window-path request pulses `miss_vld` and never `xl_vld`, whatever the other control bits hold.
- R8: Each request produces exactly one of the four pulses, one cycle later, except an illegal write, which produces none. A cycle without a request is followed by no pulse.
- R9: A register write with `cfg_we` high selects its target by `cfg_idx`: 0 is base, 1 is limit, 2 is upper target and 3 is control. The write takes effect for requests issued on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Window register write strobe |
| cfg_idx | input | 2 | Register select: 0 base, 1 limit, 2 upper target, 3 control |
| cfg_wdata | input | 32 | Register write data |
| req_vld | input | 1 | Configuration request strobe |
| req_wr | input | 1 | 1 write, 0 read |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_fn | input | 3 | Target function number |
| req_off | input | 12 | Register byte offset |
| req_wdata | input | 32 | Write data |
| loc_vld | output | 1 | Local register access pulse |
| loc_wr | output | 1 | Local access direction |
| loc_off | output | 12 | Word-aligned local offset |
| loc_wdata | output | 32 | Local write data |
| xl_vld | output | 1 | Translation pulse |
| xl_wr | output | 1 | Translated access direction |
| xl_type | output | 3 | Transaction type code |
| xl_addr | output | 32 | Translated lower target address |
| xl_addr_hi | output | 32 | Translated upper target address |
| xl_wdata | output | 32 | Translated write data |
| miss_vld | output | 1 | Window miss pulse |
| inv_rd_vld | output | 1 | Illegal-target read completion pulse |
| inv_rdata | output | 32 | All-ones data for an illegal read |

## Verification
A wrong legality decision, path choice or enable state shows up at the ports one clock after the offending request. It appears as the wrong pulse, a missing pulse, or two pulses together. A corrupted bound, type or field packing appears in the same cycle as a wrong `xl_addr`, `xl_type` or miss decision. The bench sweeps every device number across buses 0, 1, 2, 7 and 255 in both directions, with varied offsets. It repeats this with the window disabled and with narrowed bounds, so a fault in any field or any bound comparison surfaces in the first affected request.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  localparam int BUS_W = 8;
  localparam int DEV_W = 5;
  localparam int FN_W  = 3;
  localparam int OFF_W = 12;
  localparam int DW    = 32;
  localparam int AW    = 32;
  localparam int IDX_W = 2;
  localparam int TYP_W = 3;
  localparam int EN_BIT = 31;

  typedef enum logic [TYP_W-1:0] {
    XT_MEM  = 3'd0,
    XT_IO   = 3'd2,
    XT_CFG0 = 3'd4,
    XT_CFG1 = 3'd5
  } xact_e;

  typedef enum logic [IDX_W-1:0] {
    RI_BASE  = 2'd0,
    RI_LIMIT = 2'd1,
    RI_TGTHI = 2'd2,
    RI_CTRL  = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/cfgx_regs.sv
module cfgx_regs
  import cfgx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wdata,
  output logic [AW-1:0]    base_o,
  output logic [AW-1:0]    limit_o,
  output logic [AW-1:0]    tgt_hi_o,
  output logic             en_o
);
  logic [AW-1:0] base_q, limit_q, tgt_hi_q;
  logic          en_q;
  logic          base_ce, limit_ce, tgt_ce, ctrl_ce;

  always_comb begin
    base_ce  = we && (idx == RI_BASE);
    limit_ce = we && (idx == RI_LIMIT);
    tgt_ce   = we && (idx == RI_TGTHI);
    ctrl_ce  = we && (idx == RI_CTRL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      limit_q  <= '0;
      tgt_hi_q <= '0;
      en_q     <= 1'b0;
    end else begin
      if (base_ce)  base_q   <= wdata;
      if (limit_ce) limit_q  <= wdata;
      if (tgt_ce)   tgt_hi_q <= wdata;
      if (ctrl_ce)  en_q     <= wdata[EN_BIT];
    end
  end

  assign base_o   = base_q;
  assign limit_o  = limit_q;
  assign tgt_hi_o = tgt_hi_q;
  assign en_o     = en_q;
endmodule

// File: rtl/cfgx_legal.sv
module cfgx_legal
  import cfgx_pkg::*;
#(
  parameter int BUS0_DEVS = 2,
  parameter int BUS1_DEVS = 1
) (
  input  logic [BUS_W-1:0] bus,
  input  logic [DEV_W-1:0] dev,
  output logic             legal,
  output logic             is_local,
  output logic [TYP_W-1:0] typ
);
  localparam logic [DEV_W:0] B0_LIM = (DEV_W+1)'(BUS0_DEVS);
  localparam logic [DEV_W:0] B1_LIM = (DEV_W+1)'(BUS1_DEVS);

  logic [DEV_W:0] dev_x;

  always_comb begin
    dev_x    = {1'b0, dev};
    is_local = (bus == '0);
    unique case (bus)
      BUS_W'(0): legal = (dev_x < B0_LIM);
      BUS_W'(1): legal = (dev_x < B1_LIM);
      default:   legal = 1'b1;
    endcase
    typ = (bus < BUS_W'(2)) ? XT_CFG0 : XT_CFG1;
  end
endmodule

// File: rtl/cfgx_window.sv
module cfgx_window
  import cfgx_pkg::*;
#(
  parameter logic [AW-1:0] WIN_LO = 32'h01F0_0000
) (
  input  logic [BUS_W-1:0] bus,
  input  logic [DEV_W-1:0] dev,
  input  logic [FN_W-1:0]  fn,
  input  logic [OFF_W-1:0] off_al,
  input  logic [AW-1:0]    base,
  input  logic [AW-1:0]    limit,
  input  logic             en,
  output logic             hit,
  output logic [AW-1:0]    tgt_lo
);
  localparam int GAP_W = AW - BUS_W - DEV_W - FN_W - OFF_W;

  logic [AW-1:0] cmp_addr;
  logic          ge_base, le_limit;

  always_comb begin
    cmp_addr = WIN_LO + AW'(off_al);
    ge_base  = (cmp_addr >= base);
    le_limit = (cmp_addr <= limit);
    hit      = en && ge_base && le_limit;
    tgt_lo   = {bus, dev, fn, {GAP_W{1'b0}}, off_al};
  end
endmodule

// File: rtl/cfg_xlate_win.sv
module cfg_xlate_win
  import cfgx_pkg::*;
#(
  parameter logic [31:0] SPACE_BASE = 32'h0100_0000,
  parameter logic [31:0] SPACE_SIZE = 32'h0100_0000,
  parameter logic [31:0] WIN_SIZE   = 32'h0010_0000,
  parameter int          BUS0_DEVS  = 2,
  parameter int          BUS1_DEVS  = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_idx,
  input  logic [31:0] cfg_wdata,
  input  logic        req_vld,
  input  logic        req_wr,
  input  logic [7:0]  req_bus,
  input  logic [4:0]  req_dev,
  input  logic [2:0]  req_fn,
  input  logic [11:0] req_off,
  input  logic [31:0] req_wdata,
  output logic        loc_vld,
  output logic        loc_wr,
  output logic [11:0] loc_off,
  output logic [31:0] loc_wdata,
  output logic        xl_vld,
  output logic        xl_wr,
  output logic [2:0]  xl_type,
  output logic [31:0] xl_addr,
  output logic [31:0] xl_addr_hi,
  output logic [31:0] xl_wdata,
  output logic        miss_vld,
  output logic        inv_rd_vld,
  output logic [31:0] inv_rdata
);
  localparam logic [AW-1:0] WIN_LO = SPACE_BASE + SPACE_SIZE - WIN_SIZE;

  logic [AW-1:0]    base_w, limit_w, tgt_hi_w;
  logic             win_en;
  logic             legal, is_local, hit;
  logic [TYP_W-1:0] typ;
  logic [AW-1:0]    tgt_lo;
  logic [OFF_W-1:0] off_al;

  assign off_al = {req_off[OFF_W-1:2], 2'b00};

  cfgx_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .idx      (cfg_idx),
    .wdata    (cfg_wdata),
    .base_o   (base_w),
    .limit_o  (limit_w),
    .tgt_hi_o (tgt_hi_w),
    .en_o     (win_en)
  );

  cfgx_legal #(.BUS0_DEVS(BUS0_DEVS), .BUS1_DEVS(BUS1_DEVS)) u_legal (
    .bus      (req_bus),
    .dev      (req_dev),
    .legal    (legal),
    .is_local (is_local),
    .typ      (typ)
  );

  cfgx_window #(.WIN_LO(WIN_LO)) u_win (
    .bus    (req_bus),
    .dev    (req_dev),
    .fn     (req_fn),
    .off_al (off_al),
    .base   (base_w),
    .limit  (limit_w),
    .en     (win_en),
    .hit    (hit),
    .tgt_lo (tgt_lo)
  );

  // next-state
  logic take_loc, take_win;
  logic loc_vld_d, xl_vld_d, miss_d, inv_d;

  always_comb begin
    take_loc  = req_vld && legal && is_local;
    take_win  = req_vld && legal && !is_local;
    loc_vld_d = take_loc;
    xl_vld_d  = take_win && hit;
    miss_d    = take_win && !hit;
    inv_d     = req_vld && !legal && !req_wr;
  end

  // registers
  logic             loc_vld_q, xl_vld_q, miss_q, inv_q;
  logic             loc_wr_q, xl_wr_q;
  logic [OFF_W-1:0] loc_off_q;
  logic [DW-1:0]    loc_wdata_q, xl_wdata_q, inv_rdata_q;
  logic [TYP_W-1:0] xl_type_q;
  logic [AW-1:0]    xl_addr_q, xl_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_vld_q <= 1'b0;
      xl_vld_q  <= 1'b0;
      miss_q    <= 1'b0;
      inv_q     <= 1'b0;
    end else begin
      loc_vld_q <= loc_vld_d;
      xl_vld_q  <= xl_vld_d;
      miss_q    <= miss_d;
      inv_q     <= inv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_wr_q    <= 1'b0;
      loc_off_q   <= '0;
      loc_wdata_q <= '0;
    end else if (loc_vld_d) begin
      loc_wr_q    <= req_wr;
      loc_off_q   <= off_al;
      loc_wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xl_wr_q    <= 1'b0;
      xl_type_q  <= '0;
      xl_addr_q  <= '0;
      xl_hi_q    <= '0;
      xl_wdata_q <= '0;
    end else if (xl_vld_d) begin
      xl_wr_q    <= req_wr;
      xl_type_q  <= typ;
      xl_addr_q  <= tgt_lo;
      xl_hi_q    <= tgt_hi_w;
      xl_wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inv_rdata_q <= '0;
    else if (inv_d) inv_rdata_q <= '1;
  end

  assign loc_vld    = loc_vld_q;
  assign loc_wr     = loc_wr_q;
  assign loc_off    = loc_off_q;
  assign loc_wdata  = loc_wdata_q;
  assign xl_vld     = xl_vld_q;
  assign xl_wr      = xl_wr_q;
  assign xl_type    = xl_type_q;
  assign xl_addr    = xl_addr_q;
  assign xl_addr_hi = xl_hi_q;
  assign xl_wdata   = xl_wdata_q;
  assign miss_vld   = miss_q;
  assign inv_rd_vld = inv_q;
  assign inv_rdata  = inv_rdata_q;
endmodule

// File: rtl/cfgx_chk.sv
module cfgx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_vld,
  input logic        req_wr,
  input logic [7:0]  req_bus,
  input logic [4:0]  req_dev,
  input logic        loc_vld,
  input logic        xl_vld,
  input logic [2:0]  xl_type,
  input logic        miss_vld,
  input logic        inv_rd_vld,
  input logic [31:0] inv_rdata,
  input logic        win_en
);
  logic any_out;
  assign any_out = loc_vld || xl_vld || miss_vld || inv_rd_vld;

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({loc_vld, xl_vld, miss_vld, inv_rd_vld})); // R8

  AST_PULSE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    any_out |-> $past(req_vld)); // R8

  AST_ROOT_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_bus == 8'd0 && req_dev == 5'd0) |=> loc_vld); // R2

  AST_TYPE_BY_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    xl_vld |-> (xl_type == (($past(req_bus) < 8'd2) ? 3'd4 : 3'd5))); // R4

  AST_INV_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    inv_rd_vld |-> (inv_rdata == 32'hFFFF_FFFF)); // R3

  AST_BAD_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_wr && req_bus == 8'd0 && req_dev == 5'd31) |=> !any_out); // R3

  AST_XL_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    xl_vld |-> $past(win_en)); // R7
endmodule

bind cfg_xlate_win cfgx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_vld    (req_vld),
  .req_wr     (req_wr),
  .req_bus    (req_bus),
  .req_dev    (req_dev),
  .loc_vld    (loc_vld),
  .xl_vld     (xl_vld),
  .xl_type    (xl_type),
  .miss_vld   (miss_vld),
  .inv_rd_vld (inv_rd_vld),
  .inv_rdata  (inv_rdata),
  .win_en     (win_en)
);

// File: tb/cfg_xlate_win_tb.sv
module cfg_xlate_win_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_vld = 1'b0, req_wr = 1'b0;
  logic [7:0]  req_bus = '0;
  logic [4:0]  req_dev = '0;
  logic [2:0]  req_fn = '0;
  logic [11:0] req_off = '0;
  logic [31:0] req_wdata = '0;
  logic        loc_vld, loc_wr, xl_vld, xl_wr, miss_vld, inv_rd_vld;
  logic [11:0] loc_off;
  logic [31:0] loc_wdata, xl_addr, xl_addr_hi, xl_wdata, inv_rdata;
  logic [2:0]  xl_type;

  int checks = 0, fails = 0;
  logic [31:0] m_base = 0, m_limit = 0, m_hi = 0;
  logic        m_en = 0;

  always #2.5 clk = ~clk;

  cfg_xlate_win u_dut (.*);

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  function automatic logic [180:0] observe();
    logic [44:0] lp; logic [99:0] xp; logic [31:0] ip;
    lp = loc_vld ? {loc_wr, loc_off, loc_wdata} : '0;
    xp = xl_vld ? {xl_wr, xl_type, xl_addr, xl_addr_hi, xl_wdata} : '0;
    ip = inv_rd_vld ? inv_rdata : '0;
    return {loc_vld, lp, xl_vld, xp, miss_vld, inv_rd_vld, ip};
  endfunction

  task automatic check(string tag, logic [180:0] act, logic [180:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(logic [1:0] idx, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (idx)
      2'd0: m_base = d;
      2'd1: m_limit = d;
      2'd2: m_hi = d;
      default: m_en = d[31];
    endcase
  endtask

  task automatic issue(logic wr, logic [7:0] bus, logic [4:0] dev, logic [2:0] fn,
                       logic [11:0] off, logic [31:0] wd);
    logic [11:0] al; logic [31:0] ca; logic lg, hit;
    logic [44:0] lp; logic [99:0] xp; logic [31:0] ip;
    logic lv, xv, mv, iv; string tag;
    @(negedge clk);
    req_vld = 1'b1; req_wr = wr; req_bus = bus; req_dev = dev;
    req_fn = fn; req_off = off; req_wdata = wd;
    @(negedge clk);
    req_vld = 1'b0;
    al = {off[11:2], 2'b00};
    ca = 32'h01F0_0000 + {20'h0, al};
    lg = (bus == 0) ? (dev < 2) : (bus == 1) ? (dev == 0) : 1'b1;
    hit = m_en && (ca >= m_base) && (ca <= m_limit);
    lv = lg && bus == 0;
    xv = lg && bus != 0 && hit;
    mv = lg && bus != 0 && !hit;
    iv = !lg && !wr;
    lp = lv ? {wr, al, wd} : '0;
    xp = xv ? {wr, (bus < 2) ? 3'd4 : 3'd5, {bus, dev, fn, 4'h0, al}, m_hi, wd} : '0;
    ip = iv ? 32'hFFFF_FFFF : '0;
    if (lv) tag = "R2";
    else if (!lg) tag = "R3";
    else if (xv) tag = "R4/R5";
    else if (!m_en) tag = "R7";
    else tag = "R6";
    check(tag, observe(), {lv, lp, xv, xp, mv, iv, ip});
  endtask

  initial begin
    #1;
    check("R1 during reset", observe(), '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after reset", observe(), '0);
    // disabled after reset: window path misses (R7)
    issue(1'b0, 8'd3, 5'd4, 3'd1, 12'h010, 32'h0);

    // R9 register map, open window
    reg_wr(2'd0, 32'h01F0_0000);
    reg_wr(2'd1, 32'h01FF_C000);
    reg_wr(2'd2, 32'h0000_00A5);
    reg_wr(2'd3, 32'h8000_0000);

    begin
      logic [7:0] buses [5];
      buses[0] = 8'd0; buses[1] = 8'd1; buses[2] = 8'd2; buses[3] = 8'd7; buses[4] = 8'd255;
      for (int b = 0; b < 5; b++)
        for (int d = 0; d < 32; d++)
          for (int w = 0; w < 2; w++)
            issue(w[0], buses[b], d[4:0], d[2:0], 12'((d * 37 + b * 413) & 12'hFFF),
                  {buses[b], 3'(d), 21'(d * 91 + w)});
    end
    @(negedge clk);
    check("R8 idle", observe(), '0);

    // R7: bit 30 alone does not enable
    reg_wr(2'd3, 32'h4000_0000);
    for (int d = 0; d < 4; d++) begin
      issue(1'b0, 8'd1, 5'd0, 3'(d), 12'(d * 4), 32'h0);
      issue(1'b1, 8'd9, 5'(d), 3'd2, 12'h100, 32'h55);
    end
    issue(1'b1, 8'd0, 5'd1, 3'd0, 12'h3FF, 32'hCAFE); // local path unaffected, R2

    // R6: narrowed inclusive bounds
    reg_wr(2'd0, 32'h01F0_0800);
    reg_wr(2'd1, 32'h01F0_0BFC);
    reg_wr(2'd2, 32'h1234_5678);
    reg_wr(2'd3, 32'hFFFF_FFFF);
    issue(1'b0, 8'd2, 5'd3, 3'd7, 12'h7FC, 32'h0);
    issue(1'b0, 8'd2, 5'd3, 3'd7, 12'h800, 32'h0);
    issue(1'b1, 8'd1, 5'd0, 3'd5, 12'h803, 32'h1);
    issue(1'b0, 8'd2, 5'd3, 3'd7, 12'hBFC, 32'h0);
    issue(1'b0, 8'd2, 5'd3, 3'd7, 12'hBFF, 32'h0);
    issue(1'b1, 8'd2, 5'd3, 3'd7, 12'hC00, 32'h2);
    // limit below base: nothing hits
    reg_wr(2'd1, 32'h01F0_0000);
    issue(1'b0, 8'd4, 5'd1, 3'd1, 12'h900, 32'h0);
    @(negedge clk);
    check("R8 idle end", observe(), '0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule